// File: doc/BRIEF.md
# Shift-and-Reduce GF(2^8) Constant Multiplier

This block takes a stream of bytes, treats each as an element of GF(2^8), and multiplies it by one of four fixed constants: 2, 3, 16 or 17. Each byte carries a two-bit selector, so consecutive bytes may use different constants. No general multiply table is used. Doubling is a one-bit shift with a conditional XOR of the reduction polynomial. Multiplying by 16 moves the low nibble up four places and corrects for the four bits shifted out with a 16-entry reduction table. The two odd constants add the original operand back in.

The reduction polynomial is an input. Only its low byte is used, since the x^8 term is implied. The reduction table is held in registers and depends only on that polynomial. When the polynomial input changes, the block rebuilds the table at one entry per cycle and holds its input stream stalled until the rebuild is done. Both sides of the block are valid/ready byte streams. A single output register gives one cycle of latency and full throughput.

Top module: `gf_pow2_mul`

## Requirements
- R1: After reset, with `poly_i` at the default low byte 0x1B (polynomial 0x11B), `out_valid` is low and `in_ready` is high.
- R2: Selector 2'b00 yields x·2: x shifted left by one bit, XORed with `poly_i` when bit 7 of x was set.
- R3: Selector 2'b01 yields x·3, which is the x·2 result XORed with x.
- R4: Selector 2'b10 yields x·16: bits [3:0] of x moved to bits [7:4], XORed with reduction entry number x[7:4].
- R5: Selector 2'b11 yields x·17, which is the x·16 result XORed with x.
- R6: Reduction entry i (0 to 15) equals the low byte of the carry-less product of i and the polynomial. Entry 0 is therefore zero, and a byte whose high nibble is zero in mode 2'b10 comes out as its low nibble shifted up.
- R7: When `poly_i` differs from the polynomial the table was built for, `in_ready` drops in that same cycle. It stays low for exactly 17 cycles: one detection cycle and then 16 rebuild cycles. This assumes the output side is not stalled. After that, all products use the new polynomial.
- R8: The selector is sampled together with each accepted byte. Each output byte uses the selector of its own input byte.
- R9: A byte accepted at a clock edge appears on `out_valid`/`out_data` right after that edge. While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` is low.
- R10: With `out_ready` high and no rebuild pending, the block accepts one byte every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poly_i | input | 8 | Low byte of the reduction polynomial (x^8 implied) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input field element |
| in_mode | input | 2 | Constant selector: 00 ×2, 01 ×3, 10 ×16, 11 ×17 |
| out_valid | output | 1 | Product valid |
| out_ready | input | 1 | Downstream accepts the product |
| out_data | output | 8 | Product |

## Verification
The bench targets bytes whose top bit or high nibble forces a reduction, such as 0x80, 0xFF and every n<<4. A design with the wrong conditional XOR or a mis-indexed table would return an unreduced or shifted product for exactly those bytes. It changes the polynomial and counts the stall cycles, then multiplies by 16 across all high nibbles. A design that stalled for too short a time, or kept stale table entries, would miss the count or return products under the old polynomial. Random selectors change byte by byte while the output side is randomly held back. This exposes a design that sampled the selector late, dropped or repeated a byte, or changed its output while stalled.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int GF_W  = 8;
  localparam int NIB_W = GF_W / 2;
  localparam int TAB_N = 1 << NIB_W;

  typedef enum logic [1:0] {
    SEL_X2  = 2'b00,
    SEL_X3  = 2'b01,
    SEL_X16 = 2'b10,
    SEL_X17 = 2'b11
  } gfm_sel_e;

  // Low GF_W bits of the carry-less product of a nibble index and a polynomial.
  function automatic logic [GF_W-1:0] clmul_lo(input logic [NIB_W-1:0] idx,
                                               input logic [GF_W-1:0] poly);
    logic [GF_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < NIB_W; b++) begin
      if (idx[b]) acc = acc ^ (poly << b);
    end
    return acc;
  endfunction
endpackage

// File: rtl/gfm_redtab.sv
module gfm_redtab
  import gfm_pkg::*;
#(
  parameter logic [GF_W-1:0] DEFAULT_POLY = 8'h1B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GF_W-1:0]  poly_i,
  input  logic [NIB_W-1:0] rd_idx,
  output logic [GF_W-1:0]  rd_val,
  output logic [GF_W-1:0]  poly_cur,
  output logic             busy,
  output logic             pending
);
  localparam logic [NIB_W-1:0] LAST_IDX = NIB_W'(TAB_N - 1);

  logic [GF_W-1:0]  tab_q [TAB_N];
  logic             busy_q, busy_d;
  logic [NIB_W-1:0] idx_q, idx_d;
  logic [GF_W-1:0]  lat_q, lat_d;
  logic [GF_W-1:0]  cur_q, cur_d;
  logic             stale;
  logic             wr_en;
  logic [GF_W-1:0]  wr_val;

  always_comb begin
    stale  = (poly_i != cur_q);
    busy_d = busy_q;
    idx_d  = idx_q;
    lat_d  = lat_q;
    cur_d  = cur_q;
    wr_en  = 1'b0;
    wr_val = clmul_lo(idx_q, lat_q);
    if (busy_q) begin
      wr_en = 1'b1;
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        cur_d  = lat_q;
      end
    end else if (stale) begin
      busy_d = 1'b1;
      idx_d  = '0;
      lat_d  = poly_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      lat_q  <= DEFAULT_POLY;
      cur_q  <= DEFAULT_POLY;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      lat_q  <= lat_d;
      cur_q  <= cur_d;
    end
  end

  for (genvar g = 0; g < TAB_N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_q[g] <= clmul_lo(NIB_W'(g), DEFAULT_POLY);
      end else if (wr_en && (idx_q == NIB_W'(g))) begin
        tab_q[g] <= wr_val;
      end
    end
  end

  assign rd_val   = tab_q[rd_idx];
  assign poly_cur = cur_q;
  assign busy     = busy_q;
  assign pending  = busy_q | stale;
endmodule

// File: rtl/gfm_datapath.sv
module gfm_datapath
  import gfm_pkg::*;
(
  input  logic [GF_W-1:0]  x,
  input  logic [1:0]       sel,
  input  logic [GF_W-1:0]  poly,
  output logic [NIB_W-1:0] tab_idx,
  input  logic [GF_W-1:0]  tab_val,
  output logic [GF_W-1:0]  prod
);
  logic [GF_W-1:0] dbl;
  logic [GF_W-1:0] sh4;
  gfm_sel_e        sel_e;

  always_comb begin
    sel_e   = gfm_sel_e'(sel);
    tab_idx = x[GF_W-1 -: NIB_W];
    dbl     = {x[GF_W-2:0], 1'b0} ^ (x[GF_W-1] ? poly : '0);
    sh4     = {x[NIB_W-1:0], {NIB_W{1'b0}}} ^ tab_val;
    unique case (sel_e)
      SEL_X2:  prod = dbl;
      SEL_X3:  prod = dbl ^ x;
      SEL_X16: prod = sh4;
      SEL_X17: prod = sh4 ^ x;
      default: prod = dbl;
    endcase
  end
endmodule

// File: rtl/gfm_outreg.sv
module gfm_outreg
  import gfm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_in,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [GF_W-1:0] in_prod,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [GF_W-1:0] out_data
);
  logic            ov_q, ov_d;
  logic [GF_W-1:0] od_q, od_d;
  logic            take;

  always_comb begin
    in_ready = !hold_in && (!ov_q || out_ready);
    take     = in_valid && in_ready;
    ov_d     = ov_q;
    od_d     = od_q;
    if (take) begin
      ov_d = 1'b1;
      od_d = in_prod;
    end else if (out_ready) begin
      ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= ov_d;
      if (take) od_q <= od_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/gf_pow2_mul.sv
module gf_pow2_mul
  import gfm_pkg::*;
#(
  parameter logic [7:0] DEFAULT_POLY = 8'h1B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] poly_i,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] in_mode,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  logic [NIB_W-1:0] tab_idx;
  logic [GF_W-1:0]  tab_val;
  logic [GF_W-1:0]  poly_cur;
  logic             tab_busy;
  logic             tab_pending;
  logic [GF_W-1:0]  prod;

  gfm_redtab #(.DEFAULT_POLY(DEFAULT_POLY)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .poly_i   (poly_i),
    .rd_idx   (tab_idx),
    .rd_val   (tab_val),
    .poly_cur (poly_cur),
    .busy     (tab_busy),
    .pending  (tab_pending)
  );

  gfm_datapath u_dp (
    .x       (in_data),
    .sel     (in_mode),
    .poly    (poly_cur),
    .tab_idx (tab_idx),
    .tab_val (tab_val),
    .prod    (prod)
  );

  gfm_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_in   (tab_pending),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_prod   (prod),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/gfm_chk.sv
module gfm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic [1:0] in_mode,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       tab_busy
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  rebuild_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tab_busy |-> !in_ready);

  // R6
  x16_zero_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'b10 && in_data[7:4] == 4'h0)
      |=> (out_data == {$past(in_data[3:0]), 4'h0}));

  // R2
  x2_no_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 2'b00 && !in_data[7])
      |=> (out_data == {$past(in_data[6:0]), 1'b0}));
endmodule

bind gf_pow2_mul gfm_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .tab_busy  (tab_busy)
);

// File: tb/sim_gf_pow2_mul.sv
`timescale 1ns/1ps
module sim_gf_pow2_mul;
  logic       clk;
  logic       rst_n;
  logic [7:0] poly_i;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic [1:0] in_mode;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;

  logic [7:0] expq [$];
  string      tagq [$];

  logic       pv;
  logic [7:0] pd;
  logic [1:0] pm;
  logic       hold_seen;
  logic [7:0] hold_val;

  gf_pow2_mul u0 (
    .clk(clk), .rst_n(rst_n), .poly_i(poly_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] xt(input logic [7:0] x, input logic [7:0] p);
    return {x[6:0], 1'b0} ^ (x[7] ? p : 8'h00);
  endfunction

  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [1:0] m,
                                         input logic [7:0] p);
    logic [7:0] y;
    if (m[1]) y = xt(xt(xt(xt(x, p), p), p), p);
    else      y = xt(x, p);
    if (m[0]) y = y ^ x;
    return y;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2 x2";
      2'b01:   return "R3 x3";
      2'b10:   return "R4 x16";
      default: return "R5 x17";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // One clock cycle: drive at the falling edge, settle, then note what the
  // coming rising edge will transfer on each side.
  task automatic tick(input int vprob, input int rprob);
    @(negedge clk);
    if (hold_seen) chk("R9 held output stable", out_data, hold_val);
    if (!pv && ($urandom % 100) < vprob) begin
      pv = 1'b1;
      pd = 8'($urandom);
      pm = 2'($urandom);
    end
    in_valid  = pv;
    in_data   = pd;
    in_mode   = pm;
    out_ready = (($urandom % 100) < rprob);
    #1;
    hold_seen = out_valid && !out_ready;
    hold_val  = out_data;
    if (hold_seen) chk("R9 in_ready low while output stalled", {7'd0, in_ready}, 8'd0);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk("R9 unexpected output", out_data, 8'hxx);
      else chk(tagq.pop_front(), out_data, expq.pop_front());
    end
    if (in_valid && in_ready) begin
      expq.push_back(ref_mul(in_data, in_mode, poly_i));
      tagq.push_back({mode_tag(in_mode), " (R8 per-byte select)"});
      pv = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] m);
    pv = 1'b1; pd = d; pm = m;
    while (pv) tick(0, 100);
  endtask

  task automatic drain();
    for (int k = 0; k < 50 && (expq.size() != 0 || pv); k++) tick(0, 100);
    chk("R9 all bytes delivered", 8'(expq.size()), 8'd0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    pv = 1'b0; pd = '0; pm = '0; hold_seen = 1'b0; hold_val = '0;
    rst_n = 1'b0; poly_i = 8'h1B;
    in_valid = 1'b0; in_data = '0; in_mode = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 out_valid after reset", {7'd0, out_valid}, 8'd0);
    chk("R1 in_ready after reset", {7'd0, in_ready}, 8'd1);

    // Directed corner cases under 0x11B
    send(8'h80, 2'b00);   // R2 reduction: expect 0x1B
    send(8'hFF, 2'b00);   // R2: expect 0xE5
    send(8'h57, 2'b01);   // R3
    send(8'hF0, 2'b10);   // R4 full high nibble
    send(8'h0F, 2'b10);   // R6 entry 0
    send(8'hA5, 2'b11);   // R5
    send(8'h00, 2'b11);   // R5 zero
    drain();

    // R10: back-to-back acceptance
    for (int k = 0; k < 8; k++) begin
      pv = 1'b1; pd = 8'(k * 37 + 1); pm = 2'(k);
      tick(0, 100);
      chk("R10 accepted every cycle", {7'd0, pv}, 8'd0);
    end
    drain();

    // Random traffic with backpressure and per-byte selectors
    for (int k = 0; k < 600; k++) tick(70, 60);
    drain();

    // R7: polynomial change stalls the input for exactly 17 cycles
    begin
      int low_cnt;
      low_cnt = 0;
      @(negedge clk);
      poly_i = 8'h1D; in_valid = 1'b0; out_ready = 1'b1;
      #1;
      chk("R7 in_ready drops on poly change", {7'd0, in_ready}, 8'd0);
      while (!in_ready && low_cnt < 40) begin
        low_cnt++;
        @(negedge clk); #1;
      end
      chk("R7 stall length", 8'(low_cnt), 8'd17);
    end

    // R6: every reduction entry under the new polynomial
    for (int n = 0; n < 16; n++) send(8'(n << 4), 2'b10);
    send(8'h80, 2'b00);   // R7 new polynomial on x2 path: expect 0x1D
    drain();
    for (int k = 0; k < 400; k++) tick(80, 50);
    drain();

    // R7: change back while traffic is offered, then check new products
    poly_i = 8'h1B;
    for (int k = 0; k < 300; k++) tick(80, 70);
    drain();

    summary();
    $finish;
  end
endmodule